// File: doc/BRIEF.md
# Light-Load Idle Disable Timer

This block watches the conduction phases of a synchronous rectifier and drives a disable flag that sends the controller into a low-power state when switching pauses for too long. Each end of conduction starts an idle timer, and each new conduction start stops it. If the idle gap reaches the active limit, the flag is raised, the limit drops to half of the configured timeout, and the timer restarts. Only a new conduction start lowers the flag.

The limit gives hysteresis. After a disable the block waits for only half the configured timeout before it disables again. It returns to the full timeout only when a conduction start arrives after a gap of at least a quarter and less than half of the configured timeout. A shorter gap resets the timer and leaves the limit unchanged. All times are counted in clock cycles. A selection input picks one of five timeout counts given by parameters, or turns the feature off.

The control is a three-state machine:
- **ST_OFF**: the feature is off.
- **ST_COND**: conducting, with the timer idle.
- **ST_GAP**: not conducting, with the timer running.

The transitions are:
- **T_ENABLE** (ST_OFF to ST_COND): the selection becomes valid.
- **T_GAP_BEGIN** (ST_COND to ST_GAP): a conduction end arrives.
- **T_GAP_END** (ST_GAP to ST_COND): a conduction start arrives.
- **T_DISABLE_FEATURE** (any state to ST_OFF): the selection becomes invalid.

Inside ST_GAP, an expiry keeps the state and restarts the timer.

Top module: `idle_gap_guard`

## Requirements
- R1: After reset `disable_o` is 0, the state machine is in ST_COND (or ST_OFF if the selection is off), and the limit is the full configured timeout.
- R2: With no conduction start, `disable_o` rises at the clock edge exactly L cycles after the edge that sampled `cond_end_i`, where L is the active limit.
- R3: An expiry restarts the timer and sets the limit to the configured timeout shifted right by one. Further expiries keep `disable_o` at 1.
- R4: A `cond_start_i` sampled in any enabled state drives `disable_o` to 0 at the next edge and stops the timer. If a start and an expiry fall on the same edge, the start wins.
- R5: A conduction start whose elapsed gap count (edges since the `cond_end_i` edge or since the last expiry) is below the configured timeout shifted right by two leaves the limit unchanged.
- R6: A conduction start with an elapsed gap count of at least timeout>>2 and below timeout>>1 restores the full limit.
- R7: `tmo_sel_i` values 1 to 5 select the timeouts TMO_1 to TMO_5. Values 0, 6 and 7 turn the feature off: within one edge `disable_o` is 0, the timer is idle and the limit returns to full.
- R8: A `cond_end_i` sampled while the timer is already running is ignored and does not restart it.
- R9: While conducting (after a start and before the next end) the timer does not run, so `disable_o` stays 0 however long conduction lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cond_start_i | input | 1 | One-cycle pulse: sense input fell, conduction begins |
| cond_end_i | input | 1 | One-cycle pulse: sense input went positive, conduction ends |
| tmo_sel_i | input | SEL_W | Timeout selection (1..5 valid, others off) |
| disable_o | output | 1 | Low-power disable flag |

## Verification
The assertions check, on every cycle, the local rules:
- a conduction start always clears the flag;
- an invalid selection quiets the block;
- an expiry halves the limit and zeroes the timer;
- the timer counts by one only while running and is zero while conducting;
- a rising flag always follows an expiry.

Only the bench scenarios can show the long-range effects:
- the limit history across several gaps, i.e. the hysteresis;
- the exact cycle of expiry against full and half limits;
- a double expiry followed by a restore;
- an ignored repeated conduction end;
- the limit returning to full after a reset or an off period.

// File: rtl/igg_pkg.sv
package igg_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_COND = 2'd1,
        ST_GAP  = 2'd2
    } igg_state_t;

    localparam int unsigned IGG_NSEL = 5;

    function automatic int unsigned igg_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/igg_sel_decode.sv
module igg_sel_decode #(
    parameter int unsigned SEL_W = 3,
    parameter int unsigned CW    = 11,
    parameter int unsigned TMO_1 = 40,
    parameter int unsigned TMO_2 = 80,
    parameter int unsigned TMO_3 = 160,
    parameter int unsigned TMO_4 = 320,
    parameter int unsigned TMO_5 = 640
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic             en_o,
    output logic [CW-1:0]    full_o
);
    import igg_pkg::*;

    localparam int unsigned TAB [IGG_NSEL] = '{TMO_1, TMO_2, TMO_3, TMO_4, TMO_5};

    logic [IGG_NSEL-1:0] hit;
    logic [CW-1:0]       part [IGG_NSEL];

    for (genvar i = 0; i < IGG_NSEL; i++) begin : g_entry
        assign hit[i]  = (sel_i == SEL_W'(i + 1));
        assign part[i] = hit[i] ? CW'(TAB[i]) : '0;
    end

    always_comb begin
        full_o = '0;
        for (int i = 0; i < IGG_NSEL; i++) begin
            full_o = full_o | part[i];
        end
    end

    assign en_o = |hit;

endmodule

// File: rtl/igg_gap_timer.sv
module igg_gap_timer #(
    parameter int unsigned CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          lim_half_i,
    input  logic [CW-1:0] full_i,
    output logic          expire_o,
    output logic          in_win_o
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] nxt;
    logic [CW-1:0] lim;
    logic [CW-1:0] quarter;
    logic [CW-1:0] half;

    assign nxt     = cnt_q + CW'(1);
    assign quarter = full_i >> 2;
    assign half    = full_i >> 1;
    assign lim     = lim_half_i ? half : full_i;

    // nxt is the number of edges elapsed since the gap began or the last expiry
    assign expire_o = run_i && (nxt >= lim);
    assign in_win_o = (nxt >= quarter) && (nxt < half);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || expire_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= nxt;
        end
    end

    // R2: the timer advances by one on each running cycle without expiry
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !expire_o) |=> (cnt_q == $past(nxt)));

    // R3: an expiry restarts the timer
    p_expire_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> (cnt_q == '0));

    // R9: the timer is held at zero whenever it is not running
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/igg_fsm.sv
module igg_fsm
    import igg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic cond_start_i,
    input  logic cond_end_i,
    input  logic expire_i,
    input  logic in_win_i,
    output logic run_o,
    output logic lim_half_o,
    output logic dis_o
);
    igg_state_t state_q, state_d;
    logic       half_q;
    logic       dis_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (en_i) state_d = ST_COND;            // T_ENABLE
            end
            ST_COND: begin
                if (!en_i)           state_d = ST_OFF;  // T_DISABLE_FEATURE
                else if (cond_end_i) state_d = ST_GAP;  // T_GAP_BEGIN
            end
            ST_GAP: begin
                if (!en_i)             state_d = ST_OFF;  // T_DISABLE_FEATURE
                else if (cond_start_i) state_d = ST_COND; // T_GAP_END (R8: ends ignored here)
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_COND;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dis_q  <= 1'b0;
            half_q <= 1'b0;
        end else if (!en_i) begin
            dis_q  <= 1'b0;
            half_q <= 1'b0;
        end else if (cond_start_i) begin
            dis_q <= 1'b0;
            if (state_q == ST_GAP && in_win_i) half_q <= 1'b0;
        end else if (state_q == ST_GAP && expire_i) begin
            dis_q  <= 1'b1;
            half_q <= 1'b1;
        end
    end

    assign run_o      = en_i && (state_q == ST_GAP) && !cond_start_i;
    assign lim_half_o = half_q;
    assign dis_o      = dis_q;

    p_start_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && cond_start_i) |=> !dis_q);

    p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!dis_q && !half_q && state_q == ST_OFF));

    p_half_after_expire_r3: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> (half_q && dis_q));

    p_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && state_q == ST_GAP && cond_start_i && in_win_i) |=> !half_q);

    p_keep_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && state_q == ST_GAP && cond_start_i && !in_win_i) |=> (half_q == $past(half_q)));

    p_gap_needs_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COND && !cond_end_i) |=> (state_q != ST_GAP));

endmodule

// File: rtl/idle_gap_guard.sv
module idle_gap_guard #(
    parameter int unsigned SEL_W = 3,
    parameter int unsigned TMO_1 = 40,
    parameter int unsigned TMO_2 = 80,
    parameter int unsigned TMO_3 = 160,
    parameter int unsigned TMO_4 = 320,
    parameter int unsigned TMO_5 = 640
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cond_start_i,
    input  logic             cond_end_i,
    input  logic [SEL_W-1:0] tmo_sel_i,
    output logic             disable_o
);
    import igg_pkg::*;

    // every timeout is assumed to be at least 4 cycles
    localparam int unsigned TMO_MAX =
        igg_max(igg_max(igg_max(TMO_1, TMO_2), igg_max(TMO_3, TMO_4)), TMO_5);
    localparam int unsigned CW = $clog2(TMO_MAX + 1);

    logic          en;
    logic [CW-1:0] full;
    logic          run;
    logic          lim_half;
    logic          tmr_expire;
    logic          tmr_in_win;

    igg_sel_decode #(
        .SEL_W(SEL_W), .CW(CW),
        .TMO_1(TMO_1), .TMO_2(TMO_2), .TMO_3(TMO_3), .TMO_4(TMO_4), .TMO_5(TMO_5)
    ) u_dec (
        .sel_i (tmo_sel_i),
        .en_o  (en),
        .full_o(full)
    );

    igg_gap_timer #(.CW(CW)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .lim_half_i(lim_half),
        .full_i    (full),
        .expire_o  (tmr_expire),
        .in_win_o  (tmr_in_win)
    );

    igg_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en),
        .cond_start_i(cond_start_i),
        .cond_end_i  (cond_end_i),
        .expire_i    (tmr_expire),
        .in_win_i    (tmr_in_win),
        .run_o       (run),
        .lim_half_o  (lim_half),
        .dis_o       (disable_o)
    );

    // R2: the flag only rises on an expiry
    p_rise_from_expire_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disable_o) |-> $past(tmr_expire));

endmodule

// File: tb/idle_gap_guard_tb.sv
`timescale 1ns/1ps
module idle_gap_guard_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cond_start = 1'b0;
    logic       cond_end = 1'b0;
    logic [2:0] sel = 3'd1;
    logic       dis;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    idle_gap_guard u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cond_start_i(cond_start),
        .cond_end_i  (cond_end),
        .tmo_sel_i   (sel),
        .disable_o   (dis)
    );

    // sel 1: full 40, half 20, quarter 10; sel 2: full 80, half 40, quarter 20
    localparam int NV = 21;
    localparam int VSEL [NV] = '{1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,2,2,2,2};
    localparam int VGAP [NV] = '{30,45,15,30,45,5,21,20,25,10,39,41,50,30,9,40,41,85,30,79,81};
    localparam int VEXP [NV] = '{0,1,0,0,1,0,1,0,1,0,0,1,1,0,0,0,1,1,0,0,1};

    task automatic chk(input logic got, input logic exp, input string req, input string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, got, exp);
        end
    endtask

    // cond_end sampled at edge E0, cond_start sampled at edge E_g; flag sampled just before E_g
    task automatic gap_cycle(input int g, input logic exp, input string req);
        cond_end = 1'b1;
        @(negedge clk);
        cond_end = 1'b0;
        repeat (g - 1) @(negedge clk);
        chk(dis, exp, req, $sformatf("flag before start, gap %0d", g));
        cond_start = 1'b1;
        @(negedge clk);
        cond_start = 1'b0;
        chk(dis, 1'b0, "R4", $sformatf("flag after start, gap %0d", g));
    endtask

    initial begin
        #3_000_000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(dis, 1'b0, "R1", "flag in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(dis, 1'b0, "R1", "flag after reset");

        // table walk: R2 R3 R5 R6 R4 (sel 2 entries exercise R7 selection)
        for (int i = 0; i < NV; i++) begin
            sel = 3'(VSEL[i]);
            @(negedge clk);
            gap_cycle(VGAP[i], VEXP[i][0], $sformatf("R2/R3/R5/R6 vec%0d", i));
        end

        // R1: reset restores full limit (limit is half after last vector)
        rst_n = 1'b0;
        sel = 3'd1;
        repeat (2) @(negedge clk);
        chk(dis, 1'b0, "R1", "flag during mid-run reset");
        rst_n = 1'b1;
        @(negedge clk);
        gap_cycle(30, 1'b0, "R1 full limit after reset");

        // R8: second conduction end while running does not restart the timer
        cond_end = 1'b1;
        @(negedge clk);
        cond_end = 1'b0;
        repeat (14) @(negedge clk);
        cond_end = 1'b1;
        @(negedge clk);
        cond_end = 1'b0;
        repeat (24) @(negedge clk);
        chk(dis, 1'b0, "R8", "flag one edge before expiry");
        @(negedge clk);
        chk(dis, 1'b1, "R8", "flag at original expiry edge");
        cond_start = 1'b1;
        @(negedge clk);
        cond_start = 1'b0;
        chk(dis, 1'b0, "R4", "start clears flag");

        // R3: limit half now; flag persists through repeated expiries
        cond_end = 1'b1;
        @(negedge clk);
        cond_end = 1'b0;
        repeat (24) @(negedge clk);
        chk(dis, 1'b1, "R3", "flag after half-limit expiry");
        repeat (40) @(negedge clk);
        chk(dis, 1'b1, "R3", "flag held through later expiries");

        // R7: turning the feature off clears the flag
        sel = 3'd0;
        @(negedge clk);
        chk(dis, 1'b0, "R7", "flag after selection off");
        cond_end = 1'b1;
        @(negedge clk);
        cond_end = 1'b0;
        repeat (100) @(negedge clk);
        chk(dis, 1'b0, "R7", "flag stays low with sel 0");
        sel = 3'd6;
        @(negedge clk);
        cond_end = 1'b1;
        @(negedge clk);
        cond_end = 1'b0;
        repeat (100) @(negedge clk);
        chk(dis, 1'b0, "R7", "flag stays low with sel 6");

        // R7: limit back to full after off period (was half before)
        sel = 3'd1;
        @(negedge clk);
        gap_cycle(30, 1'b0, "R7 full limit after off");

        // R9: long conduction never expires
        repeat (150) @(negedge clk);
        chk(dis, 1'b0, "R9", "flag during long conduction");
        gap_cycle(41, 1'b1, "R2 expiry after long conduction");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule